// File: doc/BRIEF.md
# Recency-Ordered Segment Cache Directory

This block is the tag directory of a small cache split into six segments. It is fully associative and keeps its entries in a queue ordered by when each was last used. One end of the queue, the head, holds the entry that has gone unused longest. The other end, the tail, holds the entry touched most recently. Each lookup takes the segment tag from the address bits above the segment offset and compares it against every valid entry in parallel.

On a hit, the block answers on the next cycle and moves the matching entry to the tail. On a miss, the lookup port goes busy and the block asks main memory for the whole segment. When memory acknowledges, the new tag goes in at the tail and the head entry drops out. If the dropped entry was valid, its tag is reported as evicted so that the data array can reuse that slot. Two saturating counters record the number of hits and misses. The data array itself lives outside this block.

Top module: `seg_recency_dir`

## Requirements
- R1: After reset every entry is invalid. `req_ready` is 1, `resp_valid` and `refill_req` are 0, and both counters read 0.
- R2: The lookup tag is `req_addr[ADDR_W-1:SEG_OFF_W]`. Two addresses that differ only in the low `SEG_OFF_W` bits refer to the same segment.
- R3: A lookup that hits is accepted when `req_valid` and `req_ready` are both 1 at a clock edge. After that edge, `resp_valid`=1 and `resp_hit`=1 for one cycle, and `refill_req` stays 0.
- R4: A lookup that misses raises `refill_req` after the accepting edge, with `refill_tag` equal to the missing tag. Both are held unchanged until `refill_ack` is sampled, and `req_ready` is 0 for the whole time `refill_req` is 1.
- R5: At the edge that samples `refill_ack` during a refill, the block installs the tag. After that edge, `resp_valid`=1 and `resp_hit`=0 for one cycle, and `req_ready` returns to 1.
- R6: Invalid entries are used up before any valid entry is replaced. The first six distinct segments after reset give no eviction.
- R7: Once all six entries are valid, a miss replaces the head entry. The head entry is the one least recently hit or installed. `evict_valid`=1 and `evict_tag` report it in the same cycle as the miss response. `evict_valid` is never 1 outside a miss response.
- R8: A hit moves the entry to the tail. The entries behind it move one place toward the head, and the entries ahead of it keep their places.
- R9: `hit_count` rises by one for each hit response, and `miss_count` rises by one for each miss response. Each counter holds at its all-ones value instead of wrapping.
- R10: While a refill is pending, `req_valid` is ignored. It produces no response, and it changes neither the directory nor `refill_tag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Lookup address |
| req_ready | output | 1 | Directory can accept a lookup |
| resp_valid | output | 1 | One-cycle lookup result strobe |
| resp_hit | output | 1 | Result was a hit (1) or a miss (0) |
| evict_valid | output | 1 | A valid entry was replaced by this miss |
| evict_tag | output | ADDR_W-SEG_OFF_W | Tag of the replaced entry |
| refill_req | output | 1 | Segment fetch from main memory pending |
| refill_tag | output | ADDR_W-SEG_OFF_W | Tag of the segment to fetch |
| refill_ack | input | 1 | Main memory has delivered the segment |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |

## Verification
Two events can fall in the same cycle: a refill completes through `refill_ack`, and a new lookup is offered on `req_valid`. The bench holds `req_valid` high, with a resident tag, across the acknowledge edge. Two things are then checked. First, the edge delivers only the miss response. Second, the waiting lookup is taken on the following edge, when it is answered as a hit against the freshly reordered queue. Counter saturation is judged the same way: the miss count must stop at its all-ones value while hits continue to count.

// File: rtl/srd_pkg.sv
package srd_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REFILL = 1'b1
    } srd_state_t;
endpackage

// File: rtl/srd_match.sv
// Parallel tag compare across all directory entries.
module srd_match #(
    parameter int N     = 6,
    parameter int TAG_W = 10,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            vld,
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]        key,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);
    logic [N-1:0] eq;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign eq[i] = vld[i] && (tags[i] == key);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (eq[i] && !hit) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/srd_reorder.sv
// Remove the entry at position sel, close the gap toward the head,
// and place new_tag at the tail (position N-1).
module srd_reorder #(
    parameter int N     = 6,
    parameter int TAG_W = 10,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            vld_i,
    input  logic [N-1:0][TAG_W-1:0] tag_i,
    input  logic [IDX_W-1:0]        sel,
    input  logic [TAG_W-1:0]        new_tag,
    output logic [N-1:0]            vld_o,
    output logic [N-1:0][TAG_W-1:0] tag_o
);
    for (genvar i = 0; i < N; i++) begin : g_pos
        if (i == N - 1) begin : g_tail
            assign vld_o[i] = 1'b1;
            assign tag_o[i] = new_tag;
        end else begin : g_body
            logic keep;
            assign keep     = (IDX_W'(i) < sel);
            assign vld_o[i] = keep ? vld_i[i] : vld_i[i+1];
            assign tag_o[i] = keep ? tag_i[i] : tag_i[i+1];
        end
    end
endmodule

// File: rtl/srd_satcnt.sv
// Saturating event counter.
module srd_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != MAXV)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/seg_recency_dir.sv
module seg_recency_dir
    import srd_pkg::*;
#(
    parameter int N         = 6,
    parameter int ADDR_W    = 16,
    parameter int SEG_OFF_W = 6,
    parameter int CNT_W     = 16,
    localparam int TAG_W    = ADDR_W - SEG_OFF_W,
    localparam int IDX_W    = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              evict_valid,
    output logic [TAG_W-1:0]  evict_tag,
    output logic              refill_req,
    output logic [TAG_W-1:0]  refill_tag,
    input  logic              refill_ack,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    typedef struct packed {
        srd_state_t              st;
        logic [N-1:0]            vld;
        logic [N-1:0][TAG_W-1:0] tag;
        logic [TAG_W-1:0]        pend_tag;
        logic                    resp_valid;
        logic                    resp_hit;
        logic                    ev_valid;
        logic [TAG_W-1:0]        ev_tag;
    } dir_state_t;

    dir_state_t d, q;

    logic [TAG_W-1:0]        key;
    logic                    lk_hit;
    logic [IDX_W-1:0]        lk_idx;
    logic [IDX_W-1:0]        ro_sel;
    logic [TAG_W-1:0]        ro_new;
    logic [N-1:0]            ro_vld;
    logic [N-1:0][TAG_W-1:0] ro_tag;
    logic                    accept;
    logic                    ack_take;
    logic                    unused_offset;
    logic [N-1:0]            vld_view;

    assign key           = req_addr[ADDR_W-1:SEG_OFF_W];
    assign unused_offset = ^req_addr[SEG_OFF_W-1:0];
    assign accept        = req_valid && (q.st == ST_IDLE);
    assign ack_take      = refill_ack && (q.st == ST_REFILL);
    assign vld_view      = q.vld;

    srd_match #(.N(N), .TAG_W(TAG_W)) u_match (
        .vld  (q.vld),
        .tags (q.tag),
        .key  (key),
        .hit  (lk_hit),
        .idx  (lk_idx)
    );

    // A miss always removes the head; a hit removes its own position.
    assign ro_sel = (q.st == ST_IDLE) ? lk_idx : '0;
    assign ro_new = (q.st == ST_IDLE) ? key : q.pend_tag;

    srd_reorder #(.N(N), .TAG_W(TAG_W)) u_reorder (
        .vld_i   (q.vld),
        .tag_i   (q.tag),
        .sel     (ro_sel),
        .new_tag (ro_new),
        .vld_o   (ro_vld),
        .tag_o   (ro_tag)
    );

    always_comb begin
        d            = q;
        d.resp_valid = 1'b0;
        d.resp_hit   = 1'b0;
        d.ev_valid   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (lk_hit) begin
                        d.vld        = ro_vld;
                        d.tag        = ro_tag;
                        d.resp_valid = 1'b1;
                        d.resp_hit   = 1'b1;
                    end else begin
                        d.st       = ST_REFILL;
                        d.pend_tag = key;
                    end
                end
            end
            ST_REFILL: begin
                if (refill_ack) begin
                    d.vld        = ro_vld;
                    d.tag        = ro_tag;
                    d.ev_valid   = q.vld[0];
                    d.ev_tag     = q.tag[0];
                    d.resp_valid = 1'b1;
                    d.st         = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    srd_satcnt #(.W(CNT_W)) u_hits (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (accept && lk_hit),
        .count (hit_count)
    );

    srd_satcnt #(.W(CNT_W)) u_misses (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ack_take),
        .count (miss_count)
    );

    assign req_ready   = (q.st == ST_IDLE);
    assign refill_req  = (q.st == ST_REFILL);
    assign refill_tag  = q.pend_tag;
    assign resp_valid  = q.resp_valid;
    assign resp_hit    = q.resp_hit;
    assign evict_valid = q.ev_valid;
    assign evict_tag   = q.ev_tag;
endmodule

// File: rtl/srd_checker.sv
module srd_checker #(
    parameter int N     = 6,
    parameter int TAG_W = 10,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             resp_hit,
    input logic             evict_valid,
    input logic             refill_req,
    input logic [TAG_W-1:0] refill_tag,
    input logic             refill_ack,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count,
    input logic [N-1:0]     vld_view
);
    p_busy_not_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |-> !req_ready);

    p_refill_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && !refill_ack) |=> (refill_req && $stable(refill_tag)));

    p_ack_gives_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && refill_ack) |=> (resp_valid && !resp_hit && req_ready));

    p_hit_no_refill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> !refill_req);

    p_evict_on_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> (resp_valid && !resp_hit));

    // Valid entries stay packed at the tail end, so invalid ones go first.
    p_valid_packed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((vld_view[N-2:0] & ~vld_view[N-1:1]) == '0));

    p_busy_no_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && !refill_ack && req_valid) |=> !resp_valid);

    p_hits_monotone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hit_count >= $past(hit_count)));

    p_misses_monotone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (miss_count >= $past(miss_count)));
endmodule

bind seg_recency_dir srd_checker #(
    .N     (N),
    .TAG_W (TAG_W),
    .CNT_W (CNT_W)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .resp_valid  (resp_valid),
    .resp_hit    (resp_hit),
    .evict_valid (evict_valid),
    .refill_req  (refill_req),
    .refill_tag  (refill_tag),
    .refill_ack  (refill_ack),
    .hit_count   (hit_count),
    .miss_count  (miss_count),
    .vld_view    (vld_view)
);

// File: tb/seg_recency_dir_bench.sv
`timescale 1ns/1ps
module seg_recency_dir_bench;
    localparam int ADDR_W    = 16;
    localparam int SEG_OFF_W = 6;
    localparam int TAG_W     = ADDR_W - SEG_OFF_W;
    localparam int CNT_W     = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic              resp_valid, resp_hit, evict_valid;
    logic [TAG_W-1:0]  evict_tag, refill_tag;
    logic              refill_req;
    logic              refill_ack = 1'b0;
    logic [CNT_W-1:0]  hit_count, miss_count;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    seg_recency_dir #(
        .N(6), .ADDR_W(ADDR_W), .SEG_OFF_W(SEG_OFF_W), .CNT_W(CNT_W)
    ) u_seg_recency_dir (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_hit(resp_hit),
        .evict_valid(evict_valid), .evict_tag(evict_tag),
        .refill_req(refill_req), .refill_tag(refill_tag), .refill_ack(refill_ack),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    typedef struct packed {
        logic [TAG_W-1:0]     tag;
        logic [SEG_OFF_W-1:0] off;
        logic                 hit;
        logic                 ev;
        logic [TAG_W-1:0]     evt;
    } vec_t;

    // Queue contents head..tail noted after each step.
    localparam vec_t VECS [15] = '{
        '{10'h101, 6'h00, 1'b0, 1'b0, 10'h000}, // [1]
        '{10'h2A2, 6'h11, 1'b0, 1'b0, 10'h000}, // [1 2]
        '{10'h0F3, 6'h3F, 1'b0, 1'b0, 10'h000}, // [1 2 3]
        '{10'h314, 6'h05, 1'b0, 1'b0, 10'h000}, // [1 2 3 4]
        '{10'h005, 6'h20, 1'b0, 1'b0, 10'h000}, // [1 2 3 4 5]
        '{10'h3F6, 6'h01, 1'b0, 1'b0, 10'h000}, // [1 2 3 4 5 6] full, R6
        '{10'h101, 6'h2A, 1'b1, 1'b0, 10'h000}, // R2 other offset: [2 3 4 5 6 1]
        '{10'h127, 6'h00, 1'b0, 1'b1, 10'h2A2}, // R7 evict 2: [3 4 5 6 1 7]
        '{10'h0F3, 6'h07, 1'b1, 1'b0, 10'h000}, // hit head: [4 5 6 1 7 3]
        '{10'h208, 6'h00, 1'b0, 1'b1, 10'h314}, // evict 4: [5 6 1 7 3 8]
        '{10'h208, 6'h3C, 1'b1, 1'b0, 10'h000}, // hit tail
        '{10'h099, 6'h00, 1'b0, 1'b1, 10'h005}, // evict 5: [6 1 7 3 8 9]
        '{10'h101, 6'h00, 1'b1, 1'b0, 10'h000}, // R8 hit middle: [6 7 3 8 9 1]
        '{10'h1CA, 6'h00, 1'b0, 1'b1, 10'h3F6}, // evict 6: [7 3 8 9 1 A]
        '{10'h2A2, 6'h00, 1'b0, 1'b1, 10'h127}  // evict 7: [3 8 9 1 A 2]
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One lookup; a miss is acknowledged after two waiting cycles.
    task automatic access(input logic [ADDR_W-1:0] a, output logic hit,
                          output logic ev, output logic [TAG_W-1:0] evt);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk); #1;
        req_valid = 1'b0;
        ev  = 1'b0;
        evt = '0;
        if (resp_valid) begin
            hit = resp_hit;
            chk("R3 no refill on hit", refill_req, 0);
        end else begin
            chk("R4 refill_req", refill_req, 1);
            chk("R4 refill_tag", refill_tag, a[ADDR_W-1:SEG_OFF_W]);
            @(negedge clk);
            chk("R4 busy", req_ready, 0);
            @(negedge clk);
            refill_ack = 1'b1;
            @(posedge clk); #1;
            refill_ack = 1'b0;
            chk("R5 miss resp_valid", resp_valid, 1);
            chk("R5 ready again", req_ready, 1);
            hit = resp_hit;
            ev  = evict_valid;
            evt = evict_tag;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic h, e;
        logic [TAG_W-1:0] et;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 req_ready", req_ready, 1);
        chk("R1 resp_valid", resp_valid, 0);
        chk("R1 refill_req", refill_req, 0);
        chk("R1 hit_count", hit_count, 0);
        chk("R1 miss_count", miss_count, 0);

        for (int i = 0; i < 15; i++) begin
            access({VECS[i].tag, VECS[i].off}, h, e, et);
            chk($sformatf("R3/R5 vec%0d hit", i), h, VECS[i].hit);
            chk($sformatf("R6/R7 vec%0d evict", i), e, VECS[i].ev);
            if (VECS[i].ev) chk($sformatf("R7 vec%0d evict_tag", i), et, VECS[i].evt);
        end

        // R9: 4 hits; 11 misses saturate a 3-bit counter at 7
        chk("R9 hit_count", hit_count, 4);
        chk("R9 miss_count saturated", miss_count, 7);

        // R10 and ack/request overlap. Queue now [3 8 9 1 A 2].
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {10'h2BB, 6'h00};
        @(posedge clk); #1;
        chk("R4 refill raised", refill_req, 1);
        req_addr = {10'h0F3, 6'h00};   // held while busy
        repeat (2) begin
            @(posedge clk); #1;
            chk("R10 no resp while busy", resp_valid, 0);
            chk("R10 refill_tag kept", refill_tag, 10'h2BB);
        end
        @(negedge clk);
        refill_ack = 1'b1;
        req_addr   = {10'h208, 6'h15}; // waiting request across ack edge
        @(posedge clk); #1;
        refill_ack = 1'b0;
        chk("R5 ack resp miss", {resp_valid, resp_hit}, 2'b10);
        chk("R7 evict head", {evict_valid, evict_tag}, {1'b1, 10'h0F3});
        chk("R10 request not taken at ack", hit_count, 4);
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk("R3 waiting request hits", {resp_valid, resp_hit}, 2'b11);
        chk("R9 hit_count", hit_count, 5);
        @(posedge clk); #1;
        chk("R3 single-cycle response", resp_valid, 0);

        // R1 again: mid-run reset clears the directory
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 counters cleared", {hit_count, miss_count}, 0);
        access({10'h099, 6'h00}, h, e, et);
        chk("R1 entries invalid after reset", h, 0);
        chk("R6 no evict after reset", e, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule